// File: doc/BRIEF.md
# Three-Stage Longest-Prefix Route Lookup Pipeline

This block resolves a destination address to a route result by walking a sparse three-level table. The address is cut into a high chunk and two lower chunks. The high chunk indexes the first-level table directly. Each later level reads the word at a child base pointer plus that level's chunk. Each table word is either a leaf, which ends the walk with its value, or a pointer to the next level. Every word read at the last level is taken as the answer.

Each level has its own synchronous table with a one-cycle read latency, so the pipeline has three fixed stages. A new address can be taken on every cycle. Results come out in the order the addresses went in. A walk that meets a leaf early carries its answer through the remaining stages and reads none of their tables. The tables are filled through a simple write port before traffic starts.

The chunk widths are parameters. The setting 16/8/8, with larger second- and third-level depths, gives a 32-bit IPv4 lookup. The defaults are 8/4/4, a small configuration in which every address can be swept.

Top module: `prefix_lookup_engine`

## Requirements
- R1: After reset, outValid is 0 and inReady is 1.
- R2: A table word with bit WORD_W-1 set is a leaf, and its low WORD_W-1 bits are the result. When the first-level word at index inAddr[ADDR_W-1 -: L1W] is a leaf, outData equals its value.
- R3: A word with bit WORD_W-1 clear is a pointer, with its base in the low bits. The second-level index is (first-level base + the middle chunk inAddr[L2W+L3W-1:L3W]). A leaf found there supplies the result.
- R4: The third-level index is (second-level base + the low chunk inAddr[L3W-1:0]). The low WORD_W-1 bits of the word read there are the result, whatever its tag bit.
- R5: Every accepted address yields exactly one result, and results leave in acceptance order.
- R6: While outReady is 1, inReady is 1, so one address is accepted on each cycle.
- R7: While outValid is 1 and outReady is 0, inReady is 0. On the next cycle outValid stays 1 and outData keeps its value.
- R8: A walk that ended at an earlier level issues no read to any later table. The contents of the later tables do not change its result.
- R9: Index sums wrap modulo the depth of the table being indexed.
- R10: A table write with tblWrSel 1, 2 or 3 (first, second or third level) at tblWrAddr takes effect for addresses accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Address offered |
| inReady | output | 1 | Address taken this cycle when inValid is also 1 |
| inAddr | input | ADDR_W | Destination address |
| outValid | output | 1 | Result available |
| outReady | input | 1 | Consumer takes the result |
| outData | output | WORD_W-1 | Route result value |
| tblWrEn | input | 1 | Table write strobe |
| tblWrSel | input | 2 | Target table: 1, 2 or 3 |
| tblWrAddr | input | TBL_AW | Table write index |
| tblWrData | input | WORD_W | Table word: tag bit plus value or base |

## Verification
In one cycle the pipeline can both accept a new address at its entry and retire a result at its exit, and a consumer stall can fall in the same cycle as an offered address. The bench sweeps every address with both handshakes held high, so entry and exit coincide on every cycle, and checks that inReady never drops. A second sweep mixes input gaps with a stuttering outReady to provoke stalls. Each retired value is compared in order against an arithmetic model of the table walk, and each stalled cycle is checked for a held output and a closed input.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  // Control -> datapath strobes
  typedef struct packed {
    logic advance;
    logic rd1;
    logic rd2;
    logic rd3;
  } lpm_strobe_t;

  // Datapath -> control: walk finished at or before this stage
  typedef struct packed {
    logic leaf1;
    logic leaf2;
  } lpm_status_t;
endpackage

// File: rtl/lpm_table_mem.sv
module lpm_table_mem #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          rdEn,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) store[wrAddr] <= wrData;
    if (rdEn) rdData <= store[rdAddr];
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        outReady,
  input  lpm_status_t status,
  output logic        inReady,
  output logic        outValid,
  output lpm_strobe_t strobe
);
  logic v1, v2, v3;
  logic adv;

  assign adv = outReady | ~v3;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else if (adv) begin
      v1 <= inValid;
      v2 <= v1;
      v3 <= v2;
    end
  end

  always_comb begin
    strobe.advance = adv;
    strobe.rd1     = adv & inValid;
    strobe.rd2     = adv & v1 & ~status.leaf1;
    strobe.rd3     = adv & v2 & ~status.leaf2;
  end

  assign inReady  = adv;
  assign outValid = v3;

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  // R6
  line_rate_chk: assert property (@(posedge clk) disable iff (!rstN)
    outReady |-> inReady);
endmodule

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
#(
  parameter int L1W      = 8,
  parameter int L2W      = 4,
  parameter int L3W      = 4,
  parameter int WORD_W   = 32,
  parameter int L2_DEPTH = 64,
  parameter int L3_DEPTH = 64,
  parameter int TBL_AW   = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  lpm_strobe_t              strobe,
  input  logic [L1W+L2W+L3W-1:0]   inAddr,
  input  logic                     tblWrEn,
  input  logic [1:0]               tblWrSel,
  input  logic [TBL_AW-1:0]        tblWrAddr,
  input  logic [WORD_W-1:0]        tblWrData,
  output lpm_status_t              status,
  output logic [WORD_W-2:0]        outData
);
  localparam int ADDR_W = L1W + L2W + L3W;
  localparam int VAL_W  = WORD_W - 1;
  localparam int TAG    = WORD_W - 1;
  localparam int L1_DEPTH = 1 << L1W;
  localparam int L2_AW  = $clog2(L2_DEPTH);
  localparam int L3_AW  = $clog2(L3_DEPTH);

  logic [WORD_W-1:0]  r1Word, r2Word, r3Word;
  logic [L2W+L3W-1:0] s1Low;
  logic               s2Done;
  logic [VAL_W-1:0]   s2Val;
  logic [L3W-1:0]     s2Low;
  logic               s3Done;
  logic [VAL_W-1:0]   s3Val;
  logic [L2_AW-1:0]   idx2;
  logic [L3_AW-1:0]   idx3;

  assign idx2 = r1Word[L2_AW-1:0] + L2_AW'(s1Low[L2W+L3W-1:L3W]);
  assign idx3 = r2Word[L3_AW-1:0] + L3_AW'(s2Low);

  lpm_table_mem #(.DEPTH(L1_DEPTH), .AW(L1W), .DW(WORD_W)) tbl1_i (
    .clk(clk), .wrEn(tblWrEn && tblWrSel == 2'd1), .wrAddr(L1W'(tblWrAddr)),
    .wrData(tblWrData), .rdEn(strobe.rd1), .rdAddr(inAddr[ADDR_W-1 -: L1W]),
    .rdData(r1Word));

  lpm_table_mem #(.DEPTH(L2_DEPTH), .AW(L2_AW), .DW(WORD_W)) tbl2_i (
    .clk(clk), .wrEn(tblWrEn && tblWrSel == 2'd2), .wrAddr(L2_AW'(tblWrAddr)),
    .wrData(tblWrData), .rdEn(strobe.rd2), .rdAddr(idx2), .rdData(r2Word));

  lpm_table_mem #(.DEPTH(L3_DEPTH), .AW(L3_AW), .DW(WORD_W)) tbl3_i (
    .clk(clk), .wrEn(tblWrEn && tblWrSel == 2'd3), .wrAddr(L3_AW'(tblWrAddr)),
    .wrData(tblWrData), .rdEn(strobe.rd3), .rdAddr(idx3), .rdData(r3Word));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Low  <= '0;
      s2Done <= 1'b0;
      s2Val  <= '0;
      s2Low  <= '0;
      s3Done <= 1'b0;
      s3Val  <= '0;
    end else if (strobe.advance) begin
      s1Low  <= inAddr[L2W+L3W-1:0];
      s2Done <= r1Word[TAG];
      s2Val  <= r1Word[VAL_W-1:0];
      s2Low  <= s1Low[L3W-1:0];
      s3Done <= s2Done | r2Word[TAG];
      s3Val  <= s2Done ? s2Val : r2Word[VAL_W-1:0];
    end
  end

  assign status.leaf1 = r1Word[TAG];
  assign status.leaf2 = s2Done | r2Word[TAG];
  assign outData      = s3Done ? s3Val : r3Word[VAL_W-1:0];

  // R8
  skip_rd2_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rd2 |-> !r1Word[TAG]);

  // R8
  skip_rd3_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rd3 |-> !s2Done);
endmodule

// File: rtl/prefix_lookup_engine.sv
module prefix_lookup_engine
  import lpm_pkg::*;
#(
  parameter int L1W      = 8,
  parameter int L2W      = 4,
  parameter int L3W      = 4,
  parameter int WORD_W   = 32,
  parameter int L2_DEPTH = 64,
  parameter int L3_DEPTH = 64,
  localparam int ADDR_W  = L1W + L2W + L3W,
  localparam int L2_AW   = $clog2(L2_DEPTH),
  localparam int L3_AW   = $clog2(L3_DEPTH),
  localparam int TBL_AW  = (L1W > L2_AW) ? ((L1W > L3_AW) ? L1W : L3_AW)
                                         : ((L2_AW > L3_AW) ? L2_AW : L3_AW)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ADDR_W-1:0] inAddr,
  output logic              outValid,
  input  logic              outReady,
  output logic [WORD_W-2:0] outData,
  input  logic              tblWrEn,
  input  logic [1:0]        tblWrSel,
  input  logic [TBL_AW-1:0] tblWrAddr,
  input  logic [WORD_W-1:0] tblWrData
);
  lpm_strobe_t strobe;
  lpm_status_t status;

  lpm_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .status(status), .inReady(inReady), .outValid(outValid), .strobe(strobe));

  lpm_datapath #(
    .L1W(L1W), .L2W(L2W), .L3W(L3W), .WORD_W(WORD_W),
    .L2_DEPTH(L2_DEPTH), .L3_DEPTH(L3_DEPTH), .TBL_AW(TBL_AW)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inAddr(inAddr),
    .tblWrEn(tblWrEn), .tblWrSel(tblWrSel), .tblWrAddr(tblWrAddr),
    .tblWrData(tblWrData), .status(status), .outData(outData));

  // R7
  stall_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outData));

  // R7
  stall_closed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);
endmodule

// File: tb/prefix_lookup_engine_tb.sv
module prefix_lookup_engine_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [15:0] inAddr = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [30:0] outData;
  logic        tblWrEn = 1'b0;
  logic [1:0]  tblWrSel = '0;
  logic [7:0]  tblWrAddr = '0;
  logic [31:0] tblWrData = '0;

  int vectors = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;
  logic [15:0] expQ[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  prefix_lookup_engine dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inAddr(inAddr), .outValid(outValid), .outReady(outReady),
    .outData(outData), .tblWrEn(tblWrEn), .tblWrSel(tblWrSel),
    .tblWrAddr(tblWrAddr), .tblWrData(tblWrData));

  // Table contents, computed
  function automatic logic [31:0] t1(input int i);
    if (i % 3 == 0) return {1'b0, 31'((i * 7) % 64)};
    return {1'b1, 31'(32'h1000 + i)};
  endfunction
  function automatic logic [31:0] t2(input int j);
    if (j % 2 == 0) return {1'b0, 31'((j * 5 + 3) % 64)};
    return {1'b1, 31'(32'h2000 + j)};
  endfunction
  function automatic logic [31:0] t3(input int k);
    if (k % 5 == 0) return {1'b0, 31'(32'h3000 + k)};
    return {1'b1, 31'(32'h4000 + k)};
  endfunction

  function automatic logic [30:0] refLookup(input logic [15:0] a,
                                            output int depth, output bit wrapped);
    logic [31:0] w;
    int idx;
    wrapped = 1'b0;
    w = t1(int'(a[15:8]));
    depth = 1;
    if (w[31]) return w[30:0];
    idx = int'(w[5:0]) + int'(a[7:4]);
    if (idx >= 64) wrapped = 1'b1;
    w = t2(idx % 64);
    depth = 2;
    if (w[31]) return w[30:0];
    idx = int'(w[5:0]) + int'(a[3:0]);
    if (idx >= 64) wrapped = 1'b1;
    w = t3(idx % 64);
    depth = 3;
    return w[30:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeTbl(input logic [1:0] sel, input int addr, input logic [31:0] data);
    @(negedge clk);
    tblWrEn = 1'b1; tblWrSel = sel; tblWrAddr = 8'(addr); tblWrData = data;
    @(negedge clk);
    tblWrEn = 1'b0;
  endtask

  // Compare one retired result against the model (R5 ordering)
  task automatic retire();
    logic [15:0] a;
    logic [30:0] e;
    int d;
    bit wr;
    string tag;
    if (expQ.size() == 0) begin
      check(1'b0, "R5 extra result", {1'b0, outData}, 32'h0);
      return;
    end
    a = expQ.pop_front();
    e = refLookup(a, d, wr);
    if (d == 1) tag = "R5 R2 R8";
    else if (d == 2) tag = wr ? "R5 R3 R8 R9" : "R5 R3 R8";
    else tag = wr ? "R5 R4 R9" : "R5 R4";
    check(outData == e, tag, {1'b0, outData}, {1'b0, e});
  endtask

  // mode 0: no gaps, outReady held; mode 1: gaps and stalls
  task automatic runPhase(input int count, input int mode, input int stride);
    int sent = 0;
    bit prevStall = 1'b0;
    logic [30:0] prevData = '0;
    while (sent < count || expQ.size() > 0) begin
      @(negedge clk);
      if (mode == 0) begin
        inValid = (sent < count);
        outReady = 1'b1;
      end else begin
        inValid = (sent < count) && (cyc % 3 != 1);
        outReady = (cyc % 5 != 0) && (cyc % 7 != 3);
      end
      inAddr = 16'(sent * stride);
      #1;
      if (prevStall) begin
        check(outValid == 1'b1, "R7 valid held", {31'b0, outValid}, 32'h1);
        check(outData == prevData, "R7 data held", {1'b0, outData}, {1'b0, prevData});
      end
      if (outValid && !outReady)
        check(inReady == 1'b0, "R7 input closed", {31'b0, inReady}, 32'h0);
      if (outReady)
        check(inReady == 1'b1, "R6 accepts every cycle", {31'b0, inReady}, 32'h1);
      prevStall = outValid && !outReady;
      prevData = outData;
      if (outValid && outReady) retire();
      if (inValid && inReady) begin
        expQ.push_back(inAddr);
        sent++;
      end
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(outValid == 1'b0, "R1 outValid after reset", {31'b0, outValid}, 32'h0);
    check(inReady == 1'b1, "R1 inReady after reset", {31'b0, inReady}, 32'h1);

    for (int i = 0; i < 256; i++) writeTbl(2'd1, i, t1(i));
    for (int j = 0; j < 64; j++) writeTbl(2'd2, j, t2(j));
    for (int k = 0; k < 64; k++) writeTbl(2'd3, k, t3(k));

    runPhase(65536, 0, 1);
    runPhase(4096, 1, 17);

    // R10: reload one first-level entry and look up through it
    writeTbl(2'd1, 8'h05, {1'b1, 31'h7ABC});
    @(negedge clk);
    inValid = 1'b1; inAddr = 16'h0512; outReady = 1'b1;
    #1;
    check(inReady == 1'b1, "R10 lookup accepted", {31'b0, inReady}, 32'h1);
    @(negedge clk);
    inValid = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check(outValid == 1'b1, "R10 result valid", {31'b0, outValid}, 32'h1);
    check(outData == 31'h7ABC, "R10 reloaded leaf", {1'b0, outData}, 32'h7ABC);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 200000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule